// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block is the digital half of receive loss-of-signal supervision for a line receiver. It watches the recovered positive and negative rail data, qualified by a one-cycle bit strobe, and raises a loss flag when the line goes quiet for too long. The quiet limit depends on the selected line mode. E1 and 64 kbit/s share a short limit, and T1 uses a longer one. An external analog level comparator can also force the flag through a low-level input.

Once the flag is raised, a zero run ending is not enough to drop it. The flag drops only after the recent bit history shows enough ones density and the analog level is reported good. The block also gates the receive rails on their way out. A direct mute request forces both rails low. Optionally, the loss flag itself can be used as the mute source.

The decision logic is a two-state machine. In state `ST_SIGNAL_OK`, the *declare* transition moves it to `ST_SIGNAL_LOST` when the zero run passes the mode limit or the level input is low. In `ST_SIGNAL_LOST`, the *restore* transition returns it to `ST_SIGNAL_OK` one clock after a bit strobe if the 32-bit window holds at least 4 ones, the level is good and no excessive zero run is present. The *mode-reset* transition returns either state to `ST_SIGNAL_OK` whenever the mode input changes, and it also clears both bit-history trackers.

Top module: `los_detector`

## Requirements
- R1: After reset, `los_o` is low and `pos_o`/`neg_o` follow `pos_i`/`neg_i`.
- R2: In mode code 2'b00 (E1), 2'b01 (64 kbit/s) and 2'b11 (reserved, treated as E1), 32 consecutive strobed zeros leave `los_o` low, and the 33rd strobed zero sets it. `los_o` is high from the second clock edge after that strobe's edge onward.
- R3: In mode code 2'b10 (T1), 175 consecutive strobed zeros leave `los_o` low, and the 176th sets it.
- R4: A strobed bit with `pos_i` or `neg_i` high is a one and restarts the zero run, so 32 zeros, one one and 32 more zeros never set `los_o` in E1 mode.
- R5: While `los_o` is high, it clears on the second clock edge after a strobe that leaves at least 4 ones among the last 32 strobed bits. With 3 ones among them, it stays high.
- R6: `level_low_i` high sets `los_o` at the next clock edge, whatever the data.
- R7: While `level_low_i` is high, `los_o` does not clear even with enough ones density. After the level returns good, clearing waits for the next strobe.
- R8: A change of `mode_i` clears `los_o` at the next edge and empties both the zero-run count and the 32-bit window.
- R9: `mute_req_i` high forces `pos_o` and `neg_o` low. `mute_on_los_i` high forces them low while `los_o` is high. Otherwise they equal `pos_i`/`neg_i`.
- R10: Line data without `bit_stb_i` is ignored, so no zero is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Line mode: 00 E1, 01 64 kbit/s, 10 T1, 11 treated as E1 |
| bit_stb_i | input | 1 | One-cycle strobe qualifying one recovered bit |
| pos_i | input | 1 | Recovered positive rail data |
| neg_i | input | 1 | Recovered negative rail data |
| level_low_i | input | 1 | Analog comparator reports signal below threshold |
| mute_req_i | input | 1 | Forces output rails low |
| mute_on_los_i | input | 1 | Uses the loss flag as mute source |
| los_o | output | 1 | Loss-of-signal flag |
| pos_o | output | 1 | Gated positive rail |
| neg_o | output | 1 | Gated negative rail |

## Verification
The bench targets the exact declare thresholds on both sides (32/33 and 175/176 zeros). A counter off by one, or one that used the wrong limit for the reserved or 64 kbit/s code, would flag one bit early or late. It probes the restore boundary of three versus four ones, and a level-low that holds the flag even with good density. A design that evaluated density without the level, or with a window that never forgot, would restore too early. Mode changes mid-run and long stretches of unstrobed zeros expose counters that are not cleared, or that count clock cycles instead of bits, as a flag that rises too soon.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic [1:0] {
        MODE_E1   = 2'b00,
        MODE_K64  = 2'b01,
        MODE_T1   = 2'b10,
        MODE_RSV  = 2'b11
    } line_mode_e;

    typedef enum logic {
        ST_SIGNAL_OK   = 1'b0,
        ST_SIGNAL_LOST = 1'b1
    } los_state_e;

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
    import los_pkg::*;
#(
    parameter int SHORT_LIMIT = 32,
    parameter int LONG_LIMIT  = 175
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       stb,
    input  logic       mark,
    input  line_mode_e mode,
    output logic       run_hit
);
    localparam int CW = $clog2(LONG_LIMIT + 2);
    localparam logic [CW-1:0] SHORT_TRIP = CW'(SHORT_LIMIT + 1);
    localparam logic [CW-1:0] LONG_TRIP  = CW'(LONG_LIMIT + 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] trip;

    // trip point: one zero beyond the mode limit
    always_comb begin
        unique case (mode)
            MODE_T1:  trip = LONG_TRIP;
            default:  trip = SHORT_TRIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (stb) begin
            if (mark) begin
                run_cnt <= '0;
            end else if (run_cnt < trip) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign run_hit = (run_cnt >= trip);

endmodule

// File: rtl/los_ones_window.sv
module los_ones_window #(
    parameter int WIN_BITS = 32,
    parameter int MIN_ONES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic mark,
    output logic eval,
    output logic dens_ok
);
    localparam int PW = $clog2(WIN_BITS + 1);
    localparam logic [PW-1:0] NEED = PW'(MIN_ONES);

    logic [WIN_BITS-1:0] hist;
    logic [PW-1:0]       pop;
    logic                oldest;

    assign oldest = hist[WIN_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            pop  <= '0;
            eval <= 1'b0;
        end else if (clr) begin
            hist <= '0;
            pop  <= '0;
            eval <= 1'b0;
        end else begin
            eval <= stb;
            if (stb) begin
                hist <= {hist[WIN_BITS-2:0], mark};
                pop  <= pop + PW'(mark) - PW'(oldest);
            end
        end
    end

    assign dens_ok = (pop >= NEED);

endmodule

// File: rtl/los_mute_gate.sv
module los_mute_gate (
    input  logic pos_in,
    input  logic neg_in,
    input  logic los,
    input  logic mute_req,
    input  logic mute_on_los,
    output logic pos_out,
    output logic neg_out
);
    logic muted;

    always_comb begin
        muted   = mute_req | (mute_on_los & los);
        pos_out = pos_in & ~muted;
        neg_out = neg_in & ~muted;
    end

endmodule

// File: rtl/los_detector.sv
module los_detector
    import los_pkg::*;
#(
    parameter int E1_ZERO_LIMIT = 32,
    parameter int T1_ZERO_LIMIT = 175,
    parameter int WIN_BITS      = 32,
    parameter int MIN_ONES      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       bit_stb_i,
    input  logic       pos_i,
    input  logic       neg_i,
    input  logic       level_low_i,
    input  logic       mute_req_i,
    input  logic       mute_on_los_i,
    output logic       los_o,
    output logic       pos_o,
    output logic       neg_o
);
    line_mode_e mode_now;
    line_mode_e mode_q;
    los_state_e state_q;
    los_state_e state_d;
    logic       mark;
    logic       mode_chg;
    logic       run_hit;
    logic       eval;
    logic       dens_ok;

    assign mode_now = line_mode_e'(mode_i);
    assign mark     = pos_i | neg_i;
    assign mode_chg = (mode_now != mode_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_now;
        end else begin
            mode_q <= mode_now;
        end
    end

    los_zero_run #(
        .SHORT_LIMIT (E1_ZERO_LIMIT),
        .LONG_LIMIT  (T1_ZERO_LIMIT)
    ) i_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg),
        .stb     (bit_stb_i),
        .mark    (mark),
        .mode    (mode_now),
        .run_hit (run_hit)
    );

    los_ones_window #(
        .WIN_BITS (WIN_BITS),
        .MIN_ONES (MIN_ONES)
    ) i_ones_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg),
        .stb     (bit_stb_i),
        .mark    (mark),
        .eval    (eval),
        .dens_ok (dens_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SIGNAL_OK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: declare, restore, mode-reset
    always_comb begin
        state_d = state_q;
        if (mode_chg) begin
            state_d = ST_SIGNAL_OK;
        end else begin
            unique case (state_q)
                ST_SIGNAL_OK: begin
                    if (run_hit || level_low_i) begin
                        state_d = ST_SIGNAL_LOST;
                    end
                end
                ST_SIGNAL_LOST: begin
                    if (eval && dens_ok && !level_low_i && !run_hit) begin
                        state_d = ST_SIGNAL_OK;
                    end
                end
                default: state_d = ST_SIGNAL_OK;
            endcase
        end
    end

    // outputs
    always_comb begin
        los_o = (state_q == ST_SIGNAL_LOST);
    end

    los_mute_gate i_mute_gate (
        .pos_in      (pos_i),
        .neg_in      (neg_i),
        .los         (los_o),
        .mute_req    (mute_req_i),
        .mute_on_los (mute_on_los_i),
        .pos_out     (pos_o),
        .neg_out     (neg_o)
    );

endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       bit_stb_i,
    input logic       pos_i,
    input logic       neg_i,
    input logic       level_low_i,
    input logic       mute_req_i,
    input logic       mute_on_los_i,
    input logic       los_o,
    input logic       pos_o,
    input logic       neg_o
);
    AST_MUTE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req_i || (mute_on_los_i && los_o)) |-> (!pos_o && !neg_o)); // R9

    AST_UNMUTED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_req_i && !(mute_on_los_i && los_o)) |-> (pos_o == pos_i && neg_o == neg_i)); // R9

    AST_LEVEL_DECLARES: assert property (@(posedge clk) disable iff (!rst_n)
        (level_low_i && $stable(mode_i)) |=> los_o); // R6

    AST_NO_RESTORE_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o && level_low_i && $stable(mode_i)) |=> los_o); // R7

    AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |=> !los_o); // R8

    AST_RESTORE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_o) |-> ($past(bit_stb_i, 2) || ($past(mode_i) != $past(mode_i, 2)))); // R5

endmodule

bind los_detector los_detector_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .bit_stb_i     (bit_stb_i),
    .pos_i         (pos_i),
    .neg_i         (neg_i),
    .level_low_i   (level_low_i),
    .mute_req_i    (mute_req_i),
    .mute_on_los_i (mute_on_los_i),
    .los_o         (los_o),
    .pos_o         (pos_o),
    .neg_o         (neg_o)
);

// File: tb/test_los_detector.sv
`timescale 1ns/1ps
module test_los_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       bit_stb_i = 1'b0;
    logic       pos_i = 1'b0;
    logic       neg_i = 1'b0;
    logic       level_low_i = 1'b0;
    logic       mute_req_i = 1'b0;
    logic       mute_on_los_i = 1'b0;
    logic       los_o;
    logic       pos_o;
    logic       neg_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic rail = 1'b0;

    always #5 clk = ~clk;

    los_detector i_los_detector (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bit_stb_i(bit_stb_i),
        .pos_i(pos_i), .neg_i(neg_i), .level_low_i(level_low_i),
        .mute_req_i(mute_req_i), .mute_on_los_i(mute_on_los_i),
        .los_o(los_o), .pos_o(pos_o), .neg_o(neg_o)
    );

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic apply_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; bit_stb_i = 1'b0; pos_i = 1'b0; neg_i = 1'b0;
        level_low_i = 1'b0; mute_req_i = 1'b0; mute_on_los_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one strobed bit; returns two clocks after the sampling edge
    task automatic send_bit(input logic b);
        @(negedge clk);
        rail = ~rail;
        pos_i = b & rail; neg_i = b & ~rail; bit_stb_i = 1'b1;
        @(negedge clk);
        bit_stb_i = 1'b0; pos_i = 1'b0; neg_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic t_reset();
        apply_reset(2'b00);
        check(los_o, 1'b0, "R1 los low after reset");
        pos_i = 1'b1; #1;
        check(pos_o, 1'b1, "R1 pos passes after reset");
        pos_i = 1'b0;
    endtask

    task automatic t_short_limit(input logic [1:0] m, input string tag);
        apply_reset(m);
        send_zeros(32);
        check(los_o, 1'b0, {tag, " 32 zeros no loss"});
        send_bit(1'b0);
        check(los_o, 1'b1, {tag, " 33rd zero declares"});
    endtask

    task automatic t_t1_limit();
        apply_reset(2'b10);
        send_zeros(175);
        check(los_o, 1'b0, "R3 175 zeros no loss");
        send_bit(1'b0);
        check(los_o, 1'b1, "R3 176th zero declares");
    endtask

    task automatic t_run_restart();
        apply_reset(2'b00);
        send_zeros(32);
        send_bit(1'b1);
        send_zeros(32);
        check(los_o, 1'b0, "R4 one restarts zero run");
    endtask

    task automatic t_restore();
        apply_reset(2'b00);
        send_zeros(33);
        check(los_o, 1'b1, "R5 setup declared");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check(los_o, 1'b1, "R5 three ones keep loss");
        send_bit(1'b1);
        check(los_o, 1'b0, "R5 fourth one restores");
    endtask

    task automatic t_level();
        apply_reset(2'b10);
        @(negedge clk); level_low_i = 1'b1;
        @(negedge clk);
        check(los_o, 1'b1, "R6 level low declares next edge");
        level_low_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check(los_o, 1'b1, "R5 no restore without density");
    endtask

    task automatic t_level_blocks();
        apply_reset(2'b00);
        send_zeros(33);
        level_low_i = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        check(los_o, 1'b1, "R7 level low blocks restore");
        level_low_i = 1'b0;
        repeat (4) @(negedge clk);
        check(los_o, 1'b1, "R7 restore waits for strobe");
        send_bit(1'b0);
        check(los_o, 1'b0, "R7 restore after level good");
    endtask

    task automatic t_mode_change();
        apply_reset(2'b00);
        send_zeros(33);
        check(los_o, 1'b1, "R8 setup declared");
        @(negedge clk); mode_i = 2'b10;
        @(negedge clk);
        check(los_o, 1'b0, "R8 mode change clears");
        send_zeros(40);
        check(los_o, 1'b0, "R8 T1 counter restarted");
        @(negedge clk); mode_i = 2'b00;
        @(negedge clk);
        send_zeros(32);
        check(los_o, 1'b0, "R8 E1 counter emptied");
        send_bit(1'b0);
        check(los_o, 1'b1, "R8 E1 declares again");
    endtask

    task automatic t_mute();
        apply_reset(2'b00);
        pos_i = 1'b1; neg_i = 1'b1; mute_req_i = 1'b1; #1;
        check(pos_o, 1'b0, "R9 mute request pos low");
        check(neg_o, 1'b0, "R9 mute request neg low");
        mute_req_i = 1'b0; #1;
        check(neg_o, 1'b1, "R9 unmuted neg passes");
        pos_i = 1'b0; neg_i = 1'b0;
        send_zeros(33);
        pos_i = 1'b1; #1;
        check(pos_o, 1'b1, "R9 loss without mute source passes");
        mute_on_los_i = 1'b1; #1;
        check(pos_o, 1'b0, "R9 loss mutes when selected");
        pos_i = 1'b0; mute_on_los_i = 1'b0;
    endtask

    task automatic t_no_strobe();
        apply_reset(2'b00);
        pos_i = 1'b0; neg_i = 1'b0;
        repeat (100) @(negedge clk);
        check(los_o, 1'b0, "R10 unstrobed zeros ignored");
        send_zeros(32);
        check(los_o, 1'b0, "R10 count starts from strobes only");
        send_bit(1'b0);
        check(los_o, 1'b1, "R10 declares at 33rd strobed zero");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_short_limit(2'b00, "R2 E1");
        t_short_limit(2'b01, "R2 64k");
        t_short_limit(2'b11, "R2 reserved");
        t_t1_limit();
        t_run_restart();
        t_restore();
        t_level();
        t_level_blocks();
        t_mode_change();
        t_mute();
        t_no_strobe();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule